// File: doc/BRIEF.md
# PRBS Receive Checker with Status

This block is the receive half of a bit error rate tester. One serial bit arrives on each cycle that has the bit enable high. A local PRBS-15 generator (x^15 + x^14 + 1) locks onto that stream. While the checker hunts for the pattern, it loads the generator from the received bits themselves. Once it is locked, the generator runs free and every received bit is compared with the predicted bit. Lock is declared after a run of matching bits. Lock is dropped when errors become too dense.

Alongside the lock logic, the block counts received bits and bit errors, and it watches for long runs of zeros and of ones. An eight-bit status byte combines several kinds of bit:

- a live lock level;
- condition bits that stay pinned while their condition lasts;
- sticky event bits that a processor clears by pulsing a read strobe.

An event that lands in the same cycle as a read is never lost.

Top module: `prbs_rx_checker`

## Requirements
- R1: `sync_o` and status bit 0 rise on the bit that completes 32 consecutive matches between the received bit and the predicted bit while searching. They are both live copies of the lock state.
- R2: While in sync, lock is dropped on the bit that makes six errored bits within the last 63 received bits, counting that bit. Errors spread more thinly keep the lock. After a drop, the checker searches again.
- R3: Status bit 1 (loss of sync) becomes set one cycle after any cycle spent searching, including the first cycle after reset. A read clears it only while in sync.
- R4: Status bit 2 (all zeros) is set after 32 consecutive received zeros. A read clears it only once a one has been received since then.
- R5: Status bit 3 (all ones) is set after 32 consecutive received ones. A read clears it only once a zero has been received since then.
- R6: A 24-bit counter (parameter `ERR_CNT_W`) counts errored bits while in sync. Status bit 4 latches when the counter wraps to zero and clears on read.
- R7: A 32-bit counter (parameter `BIT_CNT_W`) counts every enabled bit. Status bit 5 latches when the counter wraps to zero and clears on read.
- R8: Status bit 6 latches on any mismatched bit received while in sync, and never while searching. It clears on read.
- R9: A sticky bit whose setting event occurs in the same cycle as `rd_stb` is set after that cycle.
- R10: During reset, every status bit and `sync_o` are zero. Status bit 7 is always zero.
- R11: A clean PRBS-15 stream, from any nonzero generator state, acquires lock within 47 bits. After lock it produces no errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Received serial data bit |
| rd_stb | input | 1 | Status read strobe, clears the clearable bits |
| status_o | output | 8 | Status byte: bit 0 sync, 1 loss of sync, 2 all zeros, 3 all ones, 4 error counter wrap, 5 bit counter wrap, 6 bit error, 7 zero |
| sync_o | output | 1 | Live lock indication |

## Verification
The hardest case to reach from the ports is the edge of the error-density window. Errors spaced 13 bits apart leave only five inside any 63-bit span, so lock must hold. Errors spaced 10 apart put six inside the span, so lock must fall on exactly the sixth. The stimulus reaches this by locking onto a clean PRBS-15 stream and then flipping chosen bits while the bench's own generator keeps running. The free-running checker stays aligned through these flips. The same sparse-error trick makes the error counter wrap without losing lock, and the bench shrinks the counter widths so that both wraps come within reach.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
    // Default geometry of the checker
    localparam int PRBS_W_DEF    = 15;
    localparam int TAP_HI_DEF    = 14;   // x^15 term -> state bit 14
    localparam int TAP_LO_DEF    = 13;   // x^14 term -> state bit 13
    localparam int SYNC_RUN_DEF  = 32;
    localparam int WIN_LEN_DEF   = 63;
    localparam int LOSS_ERRS_DEF = 6;
    localparam int RUN_LEN_DEF   = 32;
    localparam int BIT_CNT_DEF   = 32;
    localparam int ERR_CNT_DEF   = 24;

    // Status byte positions (decoded by software)
    localparam int ST_SYNC = 0;
    localparam int ST_LOS  = 1;
    localparam int ST_ZERO = 2;
    localparam int ST_ONE  = 3;
    localparam int ST_ECO  = 4;
    localparam int ST_BCO  = 5;
    localparam int ST_BED  = 6;

    typedef struct packed {
        logic bed;
        logic bco;
        logic eco;
        logic one;
        logic zer;
        logic los;
    } sticky_t;
endpackage

// File: rtl/prbs_lock.sv
module prbs_lock #(
    parameter int PRBS_W    = 15,
    parameter int TAP_HI    = 14,
    parameter int TAP_LO    = 13,
    parameter int SYNC_RUN  = 32,
    parameter int WIN_LEN   = 63,
    parameter int LOSS_ERRS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic sync_o,
    output logic err_o
);
    localparam int RUN_W = $clog2(SYNC_RUN + 1);
    localparam int WIN_W = $clog2(WIN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(SYNC_RUN - 1);
    localparam logic [WIN_W-1:0] LOSS_LIM = WIN_W'(LOSS_ERRS);

    typedef struct packed {
        logic [PRBS_W-1:0]  lfsr;
        logic               sync;
        logic [RUN_W-1:0]   run;
        logic [WIN_LEN-1:0] hist;
        logic [WIN_W-1:0]   wcnt;
    } lock_t;

    lock_t s_d, s_q;
    logic  pred, miss, err_d;
    logic [WIN_W-1:0] wsum;

    always_comb begin
        pred  = s_q.lfsr[TAP_HI] ^ s_q.lfsr[TAP_LO];
        miss  = bit_in ^ pred;
        s_d   = s_q;
        err_d = 1'b0;
        wsum  = s_q.wcnt;
        if (bit_en) begin
            if (!s_q.sync) begin
                // searching: load generator from the line
                s_d.lfsr = {s_q.lfsr[PRBS_W-2:0], bit_in};
                if (miss) begin
                    s_d.run = '0;
                end else if (s_q.run == RUN_LAST) begin
                    s_d.sync = 1'b1;
                    s_d.run  = '0;
                    s_d.hist = '0;
                    s_d.wcnt = '0;
                end else begin
                    s_d.run = s_q.run + 1'b1;
                end
            end else begin
                // locked: generator free-runs, judge every bit
                s_d.lfsr = {s_q.lfsr[PRBS_W-2:0], pred};
                err_d    = miss;
                s_d.hist = {s_q.hist[WIN_LEN-2:0], miss};
                wsum     = s_q.wcnt + WIN_W'(miss) - WIN_W'(s_q.hist[WIN_LEN-1]);
                s_d.wcnt = wsum;
                if (wsum >= LOSS_LIM) begin
                    s_d.sync = 1'b0;
                    s_d.run  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.sync;
    assign err_o  = err_d;
endmodule

// File: rtl/prbs_runs.sv
module prbs_runs #(
    parameter int   RUN_LEN = 32,
    parameter logic MARK    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic hit_o
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

    typedef struct packed {
        logic [CW-1:0] run;
    } run_t;

    run_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (bit_en) begin
            if (bit_in != MARK) begin
                r_d.run = '0;
            end else if (r_q.run != FULL) begin
                r_d.run = r_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hit_o = (r_q.run == FULL);
endmodule

// File: rtl/prbs_counter.sv
module prbs_counter #(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    output logic wrap_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d    = c_q;
        wrap_o = 1'b0;
        if (inc) begin
            c_d.cnt = c_q.cnt + 1'b1;
            wrap_o  = &c_q.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end
endmodule

// File: rtl/prbs_status.sv
module prbs_status
    import prbs_chk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_stb,
    input  logic       sync,
    input  logic       zero_hit,
    input  logic       one_hit,
    input  logic       ecnt_wrap,
    input  logic       bcnt_wrap,
    input  logic       bit_err,
    output logic [7:0] status_o
);
    sticky_t st_d, st_q;
    logic    keep;

    always_comb begin
        keep     = !rd_stb;
        // condition bits: pinned while the condition lasts
        st_d.los = !sync    | (st_q.los & keep);
        st_d.zer = zero_hit | (st_q.zer & keep);
        st_d.one = one_hit  | (st_q.one & keep);
        // events: a same-cycle event beats the read
        st_d.eco = ecnt_wrap | (st_q.eco & keep);
        st_d.bco = bcnt_wrap | (st_q.bco & keep);
        st_d.bed = bit_err   | (st_q.bed & keep);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_o          = '0;
        status_o[ST_SYNC] = sync;
        status_o[ST_LOS]  = st_q.los;
        status_o[ST_ZERO] = st_q.zer;
        status_o[ST_ONE]  = st_q.one;
        status_o[ST_ECO]  = st_q.eco;
        status_o[ST_BCO]  = st_q.bco;
        status_o[ST_BED]  = st_q.bed;
    end
endmodule

// File: rtl/prbs_rx_checker.sv
module prbs_rx_checker
    import prbs_chk_pkg::*;
#(
    parameter int PRBS_W    = PRBS_W_DEF,
    parameter int TAP_HI    = TAP_HI_DEF,
    parameter int TAP_LO    = TAP_LO_DEF,
    parameter int SYNC_RUN  = SYNC_RUN_DEF,
    parameter int WIN_LEN   = WIN_LEN_DEF,
    parameter int LOSS_ERRS = LOSS_ERRS_DEF,
    parameter int RUN_LEN   = RUN_LEN_DEF,
    parameter int BIT_CNT_W = BIT_CNT_DEF,
    parameter int ERR_CNT_W = ERR_CNT_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       rd_stb,
    output logic [7:0] status_o,
    output logic       sync_o
);
    logic       sync_w, err_w;
    logic [1:0] run_hit;   // [0] zeros, [1] ones
    logic       ecnt_wrap, bcnt_wrap;

    prbs_lock #(
        .PRBS_W(PRBS_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO),
        .SYNC_RUN(SYNC_RUN), .WIN_LEN(WIN_LEN), .LOSS_ERRS(LOSS_ERRS)
    ) u_lock (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .sync_o(sync_w), .err_o(err_w)
    );

    for (genvar gi = 0; gi < 2; gi++) begin : g_run
        prbs_runs #(.RUN_LEN(RUN_LEN), .MARK(gi == 1)) u_run (
            .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
            .hit_o(run_hit[gi])
        );
    end

    prbs_counter #(.W(ERR_CNT_W)) u_err_cnt (
        .clk(clk), .rst_n(rst_n), .inc(err_w), .wrap_o(ecnt_wrap)
    );

    prbs_counter #(.W(BIT_CNT_W)) u_bit_cnt (
        .clk(clk), .rst_n(rst_n), .inc(bit_en), .wrap_o(bcnt_wrap)
    );

    prbs_status u_status (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .sync(sync_w),
        .zero_hit(run_hit[0]), .one_hit(run_hit[1]),
        .ecnt_wrap(ecnt_wrap), .bcnt_wrap(bcnt_wrap), .bit_err(err_w),
        .status_o(status_o)
    );

    assign sync_o = sync_w;
endmodule

// File: rtl/prbs_rx_checker_sva.sv
module prbs_rx_checker_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       rd_stb,
    input logic [7:0] status_o,
    input logic       sync_o
);
    AST_SYNC_RISE_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(bit_en));                          // R1
    AST_SYNC_FALL_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_o) |-> $past(bit_en));                          // R2
    AST_LOS_WHILE_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_o |=> status_o[1]);                                  // R3
    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[2] && !rd_stb) |=> status_o[2]);                 // R4
    AST_ONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3] && !rd_stb) |=> status_o[3]);                 // R5
    AST_ECO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[4] && !rd_stb) |=> status_o[4]);                 // R6
    AST_BCO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[5] && !rd_stb) |=> status_o[5]);                 // R7
    AST_BED_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[6]) |-> $past(sync_o));                     // R8
    AST_SYNC_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] == sync_o);                                    // R1
    AST_BIT7_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[7]);                                             // R10
endmodule

bind prbs_rx_checker prbs_rx_checker_sva i_sva (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rd_stb(rd_stb),
    .status_o(status_o), .sync_o(sync_o)
);

// File: tb/test_prbs_rx_checker.sv
`timescale 1ns/1ps
module test_prbs_rx_checker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] status_o;
    logic       sync_o;
    logic [14:0] gen;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    prbs_rx_checker #(.BIT_CNT_W(10), .ERR_CNT_W(5)) i_prbs_rx_checker (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .rd_stb(rd_stb), .status_o(status_o), .sync_o(sync_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bit_en = 1'b0; rd_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        bit_en = 1'b1; bit_in = b;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        bit_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(output logic [7:0] v);
        bit_en = 1'b0; rd_stb = 1'b1;
        v = status_o;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic gen_bit(output logic b);
        b = gen[14] ^ gen[13];
        gen = {gen[13:0], b};
    endtask

    task automatic send_prbs(input int n, input logic flip_first);
        for (int i = 0; i < n; i++) begin
            logic b;
            gen_bit(b);
            send_bit(b ^ (flip_first && i == 0));
        end
    endtask

    task automatic acquire(output int used);
        used = 0;
        gen = 15'h2A5D;
        while (!sync_o && used < 64) begin
            send_prbs(1, 1'b0);
            used++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(status_o == 8'h00, "R10 status in reset", int'(status_o), 0);
        chk(sync_o == 1'b0, "R10 sync in reset", int'(sync_o), 0);
        rst_n = 1'b1;
        idle(2);
        chk(status_o == 8'h02, "R3 los set after reset", int'(status_o), 2);
    endtask

    task automatic t_zero_sync();
        logic [7:0] v;
        do_reset();
        for (int i = 0; i < 31; i++) send_bit(1'b0);
        chk(sync_o == 1'b0, "R1 no sync after 31", int'(sync_o), 0);
        send_bit(1'b0);
        chk(sync_o == 1'b1, "R1 sync after 32", int'(sync_o), 1);
        chk(status_o[0] == 1'b1, "R1 status bit0", int'(status_o[0]), 1);
        idle(2);
        chk(status_o[2] == 1'b1, "R4 zeros set", int'(status_o[2]), 1);
        do_read(v);
        chk(status_o[2] == 1'b1, "R4 zeros held without a one", int'(status_o[2]), 1);
        chk(status_o[1] == 1'b0, "R3 los cleared in sync", int'(status_o[1]), 0);
        send_bit(1'b1);
        idle(1);
        chk(status_o[6] == 1'b1, "R8 bed on error in sync", int'(status_o[6]), 1);
        do_read(v);
        chk(v[6] == 1'b1, "R8 bed read value", int'(v[6]), 1);
        chk(status_o[6] == 1'b0, "R8 bed cleared by read", int'(status_o[6]), 0);
        chk(status_o[2] == 1'b0, "R4 zeros cleared after one", int'(status_o[2]), 0);
    endtask

    task automatic t_search_ones();
        logic [7:0] v;
        do_reset();
        idle(1);
        do_read(v);
        chk(status_o[1] == 1'b1, "R3 los held while searching", int'(status_o[1]), 1);
        for (int i = 0; i < 40; i++) send_bit(1'b1);
        idle(2);
        chk(status_o[6] == 1'b0, "R8 no bed while searching", int'(status_o[6]), 0);
        chk(status_o[3] == 1'b1, "R5 ones set", int'(status_o[3]), 1);
        do_read(v);
        chk(status_o[3] == 1'b1, "R5 ones held without a zero", int'(status_o[3]), 1);
        send_bit(1'b0);
        idle(1);
        do_read(v);
        chk(status_o[3] == 1'b0, "R5 ones cleared after zero", int'(status_o[3]), 0);
    endtask

    task automatic t_prbs_lock();
        int used;
        do_reset();
        acquire(used);
        chk(used >= 32 && used <= 47, "R11 acquire length", used, 47);
        send_prbs(150, 1'b0);
        idle(1);
        chk(sync_o == 1'b1, "R11 stays locked", int'(sync_o), 1);
        chk(status_o[6] == 1'b0, "R11 no errors on clean stream", int'(status_o[6]), 0);
    endtask

    task automatic t_loss();
        int used;
        do_reset();
        acquire(used);
        for (int k = 0; k < 6; k++) send_prbs(13, 1'b1);
        chk(sync_o == 1'b1, "R2 sparse errors keep sync", int'(sync_o), 1);
        send_prbs(70, 1'b0);
        for (int k = 0; k < 5; k++) send_prbs(10, 1'b1);
        chk(sync_o == 1'b1, "R2 five errors keep sync", int'(sync_o), 1);
        send_prbs(1, 1'b1);
        chk(sync_o == 1'b0, "R2 sixth error drops sync", int'(sync_o), 0);
        idle(2);
        chk(status_o[1] == 1'b1, "R3 los set on loss", int'(status_o[1]), 1);
    endtask

    task automatic t_err_wrap();
        int used;
        logic [7:0] v;
        do_reset();
        acquire(used);
        for (int k = 0; k < 31; k++) send_prbs(13, 1'b1);
        chk(status_o[4] == 1'b0, "R6 no wrap after 31 errors", int'(status_o[4]), 0);
        send_prbs(1, 1'b1);
        chk(status_o[4] == 1'b1, "R6 wrap on 32nd error", int'(status_o[4]), 1);
        idle(1);
        do_read(v);
        chk(status_o[4] == 1'b0, "R6 wrap cleared by read", int'(status_o[4]), 0);
    endtask

    task automatic t_bit_wrap();
        logic [7:0] v;
        do_reset();
        for (int i = 0; i < 1023; i++) send_bit(i[3]);
        idle(1);
        chk(status_o[5] == 1'b0, "R7 no wrap after 1023", int'(status_o[5]), 0);
        bit_en = 1'b1; bit_in = 1'b0; rd_stb = 1'b1;
        v = status_o;
        @(negedge clk);
        bit_en = 1'b0; rd_stb = 1'b0;
        chk(status_o[5] == 1'b1, "R9 event beats same-cycle read", int'(status_o[5]), 1);
        do_read(v);
        chk(v[5] == 1'b1, "R7 wrap read value", int'(v[5]), 1);
        chk(status_o[5] == 1'b0, "R7 wrap cleared by read", int'(status_o[5]), 0);
    endtask

    initial begin
        t_reset();
        t_zero_sync();
        t_search_ones();
        t_prbs_lock();
        t_loss();
        t_err_wrap();
        t_bit_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule